// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Selectable Write Policy

This block is a direct-mapped cache placed between a processor that reads and writes single words and a main memory that answers word requests with an acknowledge. Each word address selects exactly one cache line. The cache keeps a data array and a tag array. For every line the tag array holds the stored tag, a valid flag and a modified flag, so a line is free, occupied-clean or occupied-modified.

A static parameter selects the write policy. In write-through mode every processor write reaches main memory at once. A write miss in this mode does not take a line. In write-back mode a write changes only the cache and marks the line modified. Memory is brought up to date only when a later miss needs that line's slot. In that case the whole old line is written out before the new line is read in.

The processor holds `cpu_req` and its address and data until the one-cycle `cpu_ack`. `cpu_ready` is high only while the controller is idle. On the memory side the controller holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the one-cycle `mem_ack`. On a read, `mem_rdata` is valid in the cycle of `mem_ack`.

Top module: `dm_cache`

## Requirements
- R1: The word address splits into offset `[OFFW-1:0]`, line index `[OFFW+IDXW-1:OFFW]` and tag (the bits above). With the defaults (AW=16, IDXW=4, OFFW=2) these are bits [1:0], [5:2] and [15:6]. Addresses with different indexes never displace each other.
- R2: A read miss reads the whole line from memory, one word per memory transaction, at offsets 0 up to the last offset in ascending order. It then returns the requested word.
- R3: A read that hits, or that falls in a line already filled, returns the cached word with no memory transaction.
- R4: In write-through mode (WRITE_BACK=0), a write issues exactly one memory write of the processor's address and data. On a hit it also updates the cached word. On a miss it leaves the cache unchanged, so a later read of that line misses.
- R5: In write-back mode (WRITE_BACK=1), a write hit updates the cache only and issues no memory transaction.
- R6: In write-back mode, a miss whose slot holds a modified line first writes all words of the old line to memory, at the old tag's addresses. Only then does it read any word of the new line.
- R7: A miss whose slot holds an unmodified line replaces it with no memory write.
- R8: `cpu_ready` is low from request acceptance until after `cpu_ack`, and low during every memory transaction. `cpu_ack` lasts exactly one cycle. A memory request keeps its address and write flag until `mem_ack`.
- R9: Reset clears all valid and modified flags. After reset every access misses, and a line modified before reset is never written back.
- R10: In write-back mode a write miss takes the line: the line is filled, the word is then updated, and the line is marked modified. A following read of that word returns the written value without a memory transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| cpu_ack | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | DW | Read data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle memory completion strobe |

## Verification
The same eleven-access sequence runs on one instance of each policy. It contains cold read misses, repeat reads, write hits, write misses and conflicting tags on a shared index. The per-access counts of memory reads and writes therefore separate the two policies: allocate or not, write now or later. In write-back mode, the value a read returns after a dirty line is evicted and refetched shows that the eviction carried the modified data. The order of write-before-read memory traffic shows that the eviction finishes before the refill starts. Directed accesses to neighbouring indexes, and a reset over a modified line, separate the index mapping from the flag clearing.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped cache controller.
package dmc_pkg;

    // Controller sequence: accept, look up, evict old line, fill, write through, respond.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU,
        ST_RESP
    } dmc_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
// Tag array: per line a tag, a valid flag and (write-back only) a modified flag.
// Assumes one line is addressed at a time; flags clear on synchronous reset,
// tags are not reset because they are ignored while valid is low.
module dmc_tag_store #(
    parameter int IDXW      = 4,
    parameter int TAGW      = 10,
    parameter bit HAS_DIRTY = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] idx,
    input  logic            fill_en,
    input  logic [TAGW-1:0] fill_tag,
    input  logic            dirty_set,
    output logic [TAGW-1:0] tag_o,
    output logic            valid_o,
    output logic            dirty_o
);
    localparam int LINES = 1 << IDXW;

    logic [TAGW-1:0]  tag_q [LINES];
    logic [LINES-1:0] valid_q;

    // Store the new tag when a line fill completes.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx] <= fill_tag;
    end

    // Valid flags: cleared by reset, set on fill completion.
    always_ff @(posedge clk) begin
        if (!rst_n)       valid_q      <= '0;
        else if (fill_en) valid_q[idx] <= 1'b1;
    end

    assign tag_o   = tag_q[idx];
    assign valid_o = valid_q[idx];

    generate
        if (HAS_DIRTY) begin : g_dirty
            logic [LINES-1:0] dirty_q;
            // Modified flags: cleared by reset and by a fill, set by a write hit.
            always_ff @(posedge clk) begin
                if (!rst_n)         dirty_q      <= '0;
                else if (fill_en)   dirty_q[idx] <= 1'b0;
                else if (dirty_set) dirty_q[idx] <= 1'b1;
            end
            assign dirty_o = dirty_q[idx];
        end else begin : g_no_dirty
            assign dirty_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/dmc_data_store.sv
// Data array of LINES x WORDS words, one write port and one asynchronous read port.
// Assumes the controller never reads and writes the same word in one cycle.
module dmc_data_store #(
    parameter int ADW = 6,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           we,
    input  logic [ADW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [ADW-1:0] raddr,
    output logic [DW-1:0]  rdata
);
    localparam int DEPTH = 1 << ADW;

    logic [DW-1:0] mem_q [DEPTH];

    // Write one word per cycle.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/dmc_ctrl.sv
// Cache sequencer: latches a processor request, compares tags, and runs the
// eviction, fill and write-through memory transactions one word at a time.
// Assumes the processor holds its request until cpu_ack, and memory answers
// each held request with a one-cycle mem_ack.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int IDXW       = 4,
    parameter int OFFW       = 2,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [AW-1:0]        cpu_addr,
    input  logic [DW-1:0]        cpu_wdata,
    output logic                 cpu_ready,
    output logic                 cpu_ack,
    output logic [DW-1:0]        cpu_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_ack,
    output logic [IDXW-1:0]      ts_idx,
    output logic                 ts_fill,
    output logic [AW-IDXW-OFFW-1:0] ts_fill_tag,
    output logic                 ts_dirty_set,
    input  logic [AW-IDXW-OFFW-1:0] ts_tag,
    input  logic                 ts_valid,
    input  logic                 ts_dirty,
    output logic                 ds_we,
    output logic [IDXW+OFFW-1:0] ds_waddr,
    output logic [DW-1:0]        ds_wdata,
    output logic [IDXW+OFFW-1:0] ds_raddr,
    input  logic [DW-1:0]        ds_rdata
);
    localparam int TAGW = AW - IDXW - OFFW;

    dmc_state_e      state_q;
    logic [AW-1:0]   addr_q;
    logic            we_q;
    logic [DW-1:0]   wdata_q;
    logic [DW-1:0]   rdata_q;
    logic [OFFW-1:0] cnt_q;

    logic [TAGW-1:0] req_tag;
    logic [IDXW-1:0] req_idx;
    logic [OFFW-1:0] req_off;
    logic            hit;
    logic            last_word;

    assign req_tag   = addr_q[AW-1 -: TAGW];
    assign req_idx   = addr_q[OFFW +: IDXW];
    assign req_off   = addr_q[OFFW-1:0];
    assign hit       = ts_valid && (ts_tag == req_tag);
    assign last_word = &cnt_q;

    // Sequencer state, latched request, word counter and read-data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (cpu_req) begin
                    addr_q  <= cpu_addr;
                    we_q    <= cpu_we;
                    wdata_q <= cpu_wdata;
                    state_q <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    cnt_q <= '0;
                    if (hit) begin
                        if (!we_q)           rdata_q <= ds_rdata;
                        if (we_q && !WRITE_BACK) state_q <= ST_WTHRU;
                        else                 state_q <= ST_RESP;
                    end else if (we_q && !WRITE_BACK) begin
                        state_q <= ST_WTHRU;
                    end else if (ts_valid && ts_dirty) begin
                        state_q <= ST_EVICT;
                    end else begin
                        state_q <= ST_FILL;
                    end
                end
                ST_EVICT: if (mem_ack) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_word) state_q <= ST_FILL;
                end
                ST_FILL: if (mem_ack) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_word) state_q <= ST_LOOKUP;
                end
                ST_WTHRU: if (mem_ack) state_q <= ST_RESP;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Processor-side outputs decoded from state.
    always_comb begin
        cpu_ready = (state_q == ST_IDLE);
        cpu_ack   = (state_q == ST_RESP);
        cpu_rdata = rdata_q;
    end

    // Memory-side request: eviction uses the stored tag, fill the requested tag.
    always_comb begin
        mem_req   = (state_q == ST_EVICT) || (state_q == ST_FILL) || (state_q == ST_WTHRU);
        mem_we    = (state_q == ST_EVICT) || (state_q == ST_WTHRU);
        mem_wdata = (state_q == ST_EVICT) ? ds_rdata : wdata_q;
        case (state_q)
            ST_EVICT: mem_addr = {ts_tag,  req_idx, cnt_q};
            ST_FILL:  mem_addr = {req_tag, req_idx, cnt_q};
            default:  mem_addr = addr_q;
        endcase
    end

    // Array controls: fill words from memory, write hits from the processor.
    always_comb begin
        ts_idx       = req_idx;
        ts_fill      = (state_q == ST_FILL) && mem_ack && last_word;
        ts_fill_tag  = req_tag;
        ts_dirty_set = WRITE_BACK && (state_q == ST_LOOKUP) && hit && we_q;
        ds_raddr     = {req_idx, (state_q == ST_EVICT) ? cnt_q : req_off};
        ds_we        = ((state_q == ST_FILL) && mem_ack) ||
                       ((state_q == ST_LOOKUP) && hit && we_q);
        ds_waddr     = {req_idx, (state_q == ST_FILL) ? cnt_q : req_off};
        ds_wdata     = (state_q == ST_FILL) ? mem_rdata : wdata_q;
    end

endmodule

// File: rtl/dm_cache.sv
// Direct-mapped cache top: ties the sequencer to the tag and data arrays.
// WRITE_BACK=1 selects delayed write-back, 0 selects write-through without
// write allocation. Line length is 2**OFFW words, line count 2**IDXW.
module dm_cache #(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int IDXW       = 4,
    parameter int OFFW       = 2,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ready,
    output logic          cpu_ack,
    output logic [DW-1:0] cpu_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);
    localparam int TAGW = AW - IDXW - OFFW;
    localparam int ADW  = IDXW + OFFW;

    logic [IDXW-1:0] ts_idx;
    logic            ts_fill;
    logic [TAGW-1:0] ts_fill_tag;
    logic            ts_dirty_set;
    logic [TAGW-1:0] ts_tag;
    logic            ts_valid;
    logic            ts_dirty;
    logic            ds_we;
    logic [ADW-1:0]  ds_waddr;
    logic [DW-1:0]   ds_wdata;
    logic [ADW-1:0]  ds_raddr;
    logic [DW-1:0]   ds_rdata;

    dmc_ctrl #(
        .AW(AW), .DW(DW), .IDXW(IDXW), .OFFW(OFFW), .WRITE_BACK(WRITE_BACK)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .ts_idx(ts_idx), .ts_fill(ts_fill), .ts_fill_tag(ts_fill_tag),
        .ts_dirty_set(ts_dirty_set), .ts_tag(ts_tag), .ts_valid(ts_valid),
        .ts_dirty(ts_dirty),
        .ds_we(ds_we), .ds_waddr(ds_waddr), .ds_wdata(ds_wdata),
        .ds_raddr(ds_raddr), .ds_rdata(ds_rdata)
    );

    dmc_tag_store #(
        .IDXW(IDXW), .TAGW(TAGW), .HAS_DIRTY(WRITE_BACK)
    ) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(ts_idx), .fill_en(ts_fill),
        .fill_tag(ts_fill_tag), .dirty_set(ts_dirty_set),
        .tag_o(ts_tag), .valid_o(ts_valid), .dirty_o(ts_dirty)
    );

    dmc_data_store #(
        .ADW(ADW), .DW(DW)
    ) u_data (
        .clk(clk), .we(ds_we), .waddr(ds_waddr), .wdata(ds_wdata),
        .raddr(ds_raddr), .rdata(ds_rdata)
    );

endmodule

// File: rtl/dm_cache_chk.sv
// Protocol and policy checker for dm_cache, attached by bind.
// Assumes the processor holds address and data while cpu_req is high.
module dm_cache_chk #(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int IDXW       = 4,
    parameter int OFFW       = 2,
    parameter bit WRITE_BACK = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic [AW-1:0] cpu_addr,
    input logic [DW-1:0] cpu_wdata,
    input logic          cpu_ready,
    input logic          cpu_ack,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack
);
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);  // R8
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R8
    AST_STALL_ON_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);  // R8
    AST_FILL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && mem_req && !mem_we) |-> (mem_addr[AW-1:OFFW] == cpu_addr[AW-1:OFFW]));  // R2

    generate
        if (WRITE_BACK) begin : g_wb
            AST_EVICT_SAME_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
                (cpu_req && mem_req && mem_we) |->
                    ((mem_addr[OFFW +: IDXW] == cpu_addr[OFFW +: IDXW]) &&
                     (mem_addr[AW-1:OFFW+IDXW] != cpu_addr[AW-1:OFFW+IDXW])));  // R6
        end else begin : g_wt
            AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
                (cpu_req && mem_req && mem_we) |->
                    ((mem_addr == cpu_addr) && (mem_wdata == cpu_wdata)));  // R4
        end
    endgenerate

endmodule

bind dm_cache dm_cache_chk #(
    .AW(AW), .DW(DW), .IDXW(IDXW), .OFFW(OFFW), .WRITE_BACK(WRITE_BACK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_ack(cpu_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/dm_cache_tb.sv
`timescale 1ns/1ps

// Behavioural main memory: 1024 words, acknowledges after LAT cycles,
// counts reads and writes and remembers the read count at the latest write.
module dmc_mem_model #(
    parameter int LAT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [15:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        ack,
    output int          n_rd,
    output int          n_wr,
    output int          n_rd_at_wr
);
    logic [31:0] mem [1024];
    int          cnt;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 | i;
        n_rd = 0; n_wr = 0; n_rd_at_wr = 0;
        ack = 1'b0; cnt = 0; rdata = '0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
            cnt <= 0;
        end else begin
            ack <= 1'b0;
            if (req && !ack) begin
                if (cnt == LAT - 1) begin
                    cnt <= 0;
                    ack <= 1'b1;
                    if (we) begin
                        mem[addr[9:0]] <= wdata;
                        n_wr           <= n_wr + 1;
                        n_rd_at_wr     <= n_rd;
                    end else begin
                        rdata <= mem[addr[9:0]];
                        n_rd  <= n_rd + 1;
                    end
                end else begin
                    cnt <= cnt + 1;
                end
            end
        end
    end
endmodule

module dm_cache_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // Write-back instance (b_) and write-through instance (t_).
    logic        b_req = 0, b_we = 0, t_req = 0, t_we = 0;
    logic [15:0] b_addr = 0, t_addr = 0;
    logic [31:0] b_wdata = 0, t_wdata = 0;
    logic        b_ready, b_ack, t_ready, t_ack;
    logic [31:0] b_rdata, t_rdata;
    logic        b_mreq, b_mwe, b_mack, t_mreq, t_mwe, t_mack;
    logic [15:0] b_maddr, t_maddr;
    logic [31:0] b_mwdata, b_mrdata, t_mwdata, t_mrdata;
    int          b_nrd, b_nwr, b_rdw, t_nrd, t_nwr, t_rdw;

    dm_cache #(.WRITE_BACK(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(b_req), .cpu_we(b_we), .cpu_addr(b_addr),
        .cpu_wdata(b_wdata), .cpu_ready(b_ready), .cpu_ack(b_ack), .cpu_rdata(b_rdata),
        .mem_req(b_mreq), .mem_we(b_mwe), .mem_addr(b_maddr), .mem_wdata(b_mwdata),
        .mem_rdata(b_mrdata), .mem_ack(b_mack)
    );
    dmc_mem_model #(.LAT(2)) u_mem_b (
        .clk(clk), .rst_n(rst_n), .req(b_mreq), .we(b_mwe), .addr(b_maddr),
        .wdata(b_mwdata), .rdata(b_mrdata), .ack(b_mack),
        .n_rd(b_nrd), .n_wr(b_nwr), .n_rd_at_wr(b_rdw)
    );

    dm_cache #(.WRITE_BACK(1'b0)) u_dut_wt (
        .clk(clk), .rst_n(rst_n), .cpu_req(t_req), .cpu_we(t_we), .cpu_addr(t_addr),
        .cpu_wdata(t_wdata), .cpu_ready(t_ready), .cpu_ack(t_ack), .cpu_rdata(t_rdata),
        .mem_req(t_mreq), .mem_we(t_mwe), .mem_addr(t_maddr), .mem_wdata(t_mwdata),
        .mem_rdata(t_mrdata), .mem_ack(t_mack)
    );
    dmc_mem_model #(.LAT(3)) u_mem_t (
        .clk(clk), .rst_n(rst_n), .req(t_mreq), .we(t_mwe), .addr(t_maddr),
        .wdata(t_mwdata), .rdata(t_mrdata), .ack(t_mack),
        .n_rd(t_nrd), .n_wr(t_nwr), .n_rd_at_wr(t_rdw)
    );

    int n_chk = 0;
    int n_bad = 0;
    int b_stall_err = 0;
    int t_stall_err = 0;

    // Memory busy while processor side reports ready is a stall violation (R8).
    always @(negedge clk) begin
        if (rst_n && b_mreq && b_ready) b_stall_err++;
        if (rst_n && t_mreq && t_ready) t_stall_err++;
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // One processor access; returns read data, memory traffic and eviction order.
    task automatic access(input bit wt, input bit we, input logic [15:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int nrd, output int nwr, output bit ord_ok);
        int  r0, w0;
        bit  got;
        got = 0;
        r0 = wt ? t_nrd : b_nrd;
        w0 = wt ? t_nwr : b_nwr;
        @(negedge clk);
        if (wt) begin t_req = 1; t_we = we; t_addr = a; t_wdata = wd; end
        else    begin b_req = 1; b_we = we; b_addr = a; b_wdata = wd; end
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if ((wt ? t_ack : b_ack) == 1'b1) begin got = 1; break; end
        end
        chk(got, "R8 watchdog", 32'(got), 32'd1);
        rd = wt ? t_rdata : b_rdata;
        if (wt) t_req = 0; else b_req = 0;
        @(negedge clk);
        chk((wt ? t_ack : b_ack) == 1'b0 && (wt ? t_ready : b_ready) == 1'b1,
            "R8 ack pulse", 32'(wt ? t_ack : b_ack), 32'd0);
        nrd = (wt ? t_nrd : b_nrd) - r0;
        nwr = (wt ? t_nwr : b_nwr) - w0;
        ord_ok = (nwr == 0) || ((wt ? t_rdw : b_rdw) == r0);
    endtask

    // Stimulus and expected traffic per access. Address = tag*64 + index*4 + offset.
    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [3:0]  b_rd, b_wr, t_rd, t_wr;
        logic [3:0]  b_rq, t_rq;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{1'b0, 16'd73,  32'h0,         4'd4, 4'd0, 4'd4, 4'd0, 4'd2,  4'd2},  // R2 cold miss
        '{1'b0, 16'd75,  32'h0,         4'd0, 4'd0, 4'd0, 4'd0, 4'd3,  4'd3},  // R3 same line
        '{1'b1, 16'd72,  32'h1111_AAAA, 4'd0, 4'd0, 4'd0, 4'd1, 4'd5,  4'd4},  // R5 / R4 write hit
        '{1'b0, 16'd72,  32'h0,         4'd0, 4'd0, 4'd0, 4'd0, 4'd3,  4'd3},  // R3 read back
        '{1'b0, 16'd136, 32'h0,         4'd4, 4'd4, 4'd4, 4'd0, 4'd6,  4'd7},  // R6 / R7 conflict
        '{1'b0, 16'd72,  32'h0,         4'd4, 4'd0, 4'd4, 4'd0, 4'd7,  4'd7},  // R7 clean replace
        '{1'b1, 16'd214, 32'h2222_BBBB, 4'd4, 4'd0, 4'd0, 4'd1, 4'd10, 4'd4},  // R10 / R4 write miss
        '{1'b0, 16'd214, 32'h0,         4'd0, 4'd0, 4'd4, 4'd0, 4'd3,  4'd4},  // R3 / R4 no allocate
        '{1'b1, 16'd277, 32'h3333_CCCC, 4'd4, 4'd4, 4'd0, 4'd1, 4'd6,  4'd4},  // R6 / R4
        '{1'b0, 16'd214, 32'h0,         4'd4, 4'd4, 4'd0, 4'd0, 4'd6,  4'd3},  // R6 / R3
        '{1'b0, 16'd277, 32'h0,         4'd4, 4'd0, 4'd4, 4'd0, 4'd7,  4'd2}   // R7 / R2
    };

    logic [31:0] exp_b [1024];
    logic [31:0] exp_t [1024];

    initial begin : watchdog
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int          nrd, nwr;
        bit          ord;
        string       tg;

        for (int i = 0; i < 1024; i++) begin
            exp_b[i] = 32'hC0DE_0000 | i;
            exp_t[i] = 32'hC0DE_0000 | i;
        end

        repeat (3) @(negedge clk);
        // Reset state (R9 / R8): idle, no strobe, no memory request.
        chk(b_ready && !b_ack && !b_mreq, "R9 reset state", {29'd0, b_ready, b_ack, b_mreq}, 32'h4);
        chk(t_ready && !t_ack && !t_mreq, "R9 reset state", {29'd0, t_ready, t_ack, t_mreq}, 32'h4);
        rst_n = 1;
        @(negedge clk);

        // Table walk, both policies.
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 11; v++) begin
                access(p == 1, VEC[v].we, VEC[v].addr, VEC[v].wdata, rd, nrd, nwr, ord);
                tg = $sformatf("R%0d vec %0d %s", (p == 1) ? VEC[v].t_rq : VEC[v].b_rq, v,
                               (p == 1) ? "wt" : "wb");
                if (VEC[v].we) begin
                    if (p == 1) exp_t[VEC[v].addr[9:0]] = VEC[v].wdata;
                    else        exp_b[VEC[v].addr[9:0]] = VEC[v].wdata;
                end else begin
                    chk(rd == ((p == 1) ? exp_t[VEC[v].addr[9:0]] : exp_b[VEC[v].addr[9:0]]),
                        {tg, " data"}, rd, (p == 1) ? exp_t[VEC[v].addr[9:0]] : exp_b[VEC[v].addr[9:0]]);
                end
                chk(nrd == int'((p == 1) ? VEC[v].t_rd : VEC[v].b_rd), {tg, " mem reads"},
                    32'(nrd), 32'((p == 1) ? VEC[v].t_rd : VEC[v].b_rd));
                chk(nwr == int'((p == 1) ? VEC[v].t_wr : VEC[v].b_wr), {tg, " mem writes"},
                    32'(nwr), 32'((p == 1) ? VEC[v].t_wr : VEC[v].b_wr));
                chk(ord, {tg, " R6 evict before fill"}, 32'(ord), 32'd1);
            end
        end

        // R1: neighbouring indexes coexist; tag 7 index 9 and tag 8 index 10.
        access(1, 0, 16'd484, 32'h0, rd, nrd, nwr, ord);
        chk(nrd == 4, "R1 first line fill", 32'(nrd), 32'd4);
        access(1, 0, 16'd552, 32'h0, rd, nrd, nwr, ord);
        chk(nrd == 4 && nwr == 0, "R1 second index", 32'(nrd), 32'd4);
        access(1, 0, 16'd487, 32'h0, rd, nrd, nwr, ord);
        chk(nrd == 0, "R1 first line kept", 32'(nrd), 32'd0);
        chk(rd == exp_t[487], "R1 data", rd, exp_t[487]);

        // R9: modify a cached line, reset, then the modification is lost and not written back.
        access(0, 1, 16'd72, 32'h4444_DDDD, rd, nrd, nwr, ord);
        chk(nrd == 0 && nwr == 0, "R5 write hit before reset", 32'(nrd + nwr), 32'd0);
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk(b_ready && !b_mreq, "R9 idle in reset", {30'd0, b_ready, b_mreq}, 32'h2);
        rst_n = 1;
        @(negedge clk);
        access(0, 0, 16'd72, 32'h0, rd, nrd, nwr, ord);
        chk(nrd == 4, "R9 miss after reset", 32'(nrd), 32'd4);
        chk(nwr == 0, "R9 no write-back after reset", 32'(nwr), 32'd0);
        chk(rd == 32'h1111_AAAA, "R9 memory value", rd, 32'h1111_AAAA);

        // R8: memory never busy while the processor side reports ready.
        chk(b_stall_err == 0, "R8 stall wb", 32'(b_stall_err), 32'd0);
        chk(t_stall_err == 0, "R8 stall wt", 32'(t_stall_err), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule